// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer for a single successive-approximation analog-to-digital conversion. It drives a trial code into an external resistor-ladder DAC and comparator and reads back one comparator decision per bit. Bits are settled from the most significant one downward. The conversion resolution is either 8 or 10 bits. A sample-and-hold setting shortens the conversion. Each of the four mode combinations has a fixed total length in converter clocks.

A conversion starts on a `start` request. The request is taken only while the reference ladder is connected (`ref_en` high) and the block is idle. The block first spends a sampling phase with the ladder code held at zero. It then runs one evenly spaced trial per bit. It ends with a one-clock `done` pulse. The result is split into a low byte and a 2-bit high field. The result registers hold their value until the next conversion completes.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While and after reset, `busy`, `done`, `res_lo`, `res_hi` and `trial_code` are all zero.
- R2: A `start` request is accepted only when `ref_en` is 1 and `busy` is 0. With `ref_en` at 0 the block stays idle, `trial_code` stays zero and the result is unchanged.
- R3: The conversion length is fixed by the mode captured at the accepted start. With 8-bit resolution and no sample-and-hold, `done` rises exactly 49 clock edges after the accepting edge. The other lengths are 59 for 10-bit without sample-and-hold, 28 for 8-bit with sample-and-hold, and 33 for 10-bit with sample-and-hold.
- R4: The conversion opens with a sampling phase in which `trial_code` is zero. Its length is the total minus bits times step: 9, 9, 4 and 3 cycles for the four modes in the order of R3. `trial_code` is zero whenever `busy` is 0.
- R5: Each bit trial lasts a fixed step of 5 cycles without sample-and-hold and 3 cycles with it. Trials run from bit 9 (10-bit mode) or bit 7 (8-bit mode) down to bit 0. During a trial, `trial_code` equals the bits already decided, OR a one in the bit under test.
- R6: The comparator input `cmp_hi` is sampled on the last cycle of each trial. A 1 (input at or above the trial level) keeps the bit under test and a 0 clears it.
- R7: `done` is high for exactly one clock, in the cycle after the final decision is latched. `busy` is low in that cycle.
- R8: `res_lo` carries result bits 7:0. `res_hi` carries bits 9:8 in 10-bit mode and reads zero in 8-bit mode.
- R9: `res_lo` and `res_hi` change only in a cycle where `done` is high. They stay stable through idle time and through the following conversion.
- R10: While `busy` is high, further `start` requests and changes on `res_full` or `hold_en` have no effect on the running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference ladder connected; required for a start |
| start | input | 1 | Conversion request, sampled each clock |
| res_full | input | 1 | 1 selects 10-bit, 0 selects 8-bit resolution |
| hold_en | input | 1 | 1 selects the sample-and-hold timing |
| cmp_hi | input | 1 | Comparator: analog input at or above trial level |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock completion pulse |
| res_lo | output | 8 | Result bits 7:0 |
| res_hi | output | 2 | Result bits 9:8, zero in 8-bit mode |
| trial_code | output | 10 | Code presented to the ladder DAC |

## Verification
`busy` rises one edge after an accepted start. `done` follows exactly 49, 59, 28 or 33 edges after that start, and the result registers change on that same edge. The first trial code appears after the sampling cycles, and each decision shows in the following trial's code one edge after the last cycle of its own trial. The bench holds a behavioural model that steps on each rising edge from the same inputs and its own comparator function. It compares every output on the falling edge, so every expected value is read half a cycle after the edge that produced it. Directed runs also count falling edges from the start request to `done` and check the settled result against the analog value.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2
    } sar_phase_e;

    typedef struct packed {
        logic full;
        logic hold;
    } sar_mode_t;

    function automatic int sample_len(input int total, input int bits, input int step);
        return total - bits * step;
    endfunction

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
    import sar_pkg::*;
#(
    parameter int FULL_BITS  = 10,
    parameter int SHORT_BITS = 8,
    parameter int CNT_W      = 6,
    parameter int IDX_W      = 4,
    parameter int STEP_PLAIN = 5,
    parameter int STEP_SH    = 3,
    parameter int SAMP_S     = 9,
    parameter int SAMP_F     = 9,
    parameter int SAMP_S_SH  = 4,
    parameter int SAMP_F_SH  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  sar_mode_t        mode_in,
    output logic             busy,
    output logic             trial_on,
    output logic [IDX_W-1:0] bit_pos,
    output logic             decide,
    output logic             final_bit,
    output logic             full_q
);

    sar_phase_e       phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] step_q;
    logic [CNT_W-1:0] samp_q;
    logic [CNT_W-1:0] sel_step;
    logic [CNT_W-1:0] sel_samp;
    logic [IDX_W-1:0] sel_top;

    always_comb begin
        sel_step = mode_in.hold ? CNT_W'(STEP_SH) : CNT_W'(STEP_PLAIN);
        unique case ({mode_in.full, mode_in.hold})
            2'b00:   sel_samp = CNT_W'(SAMP_S);
            2'b10:   sel_samp = CNT_W'(SAMP_F);
            2'b01:   sel_samp = CNT_W'(SAMP_S_SH);
            default: sel_samp = CNT_W'(SAMP_F_SH);
        endcase
        sel_top = mode_in.full ? IDX_W'(FULL_BITS - 1) : IDX_W'(SHORT_BITS - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            step_q  <= '0;
            samp_q  <= '0;
            bit_pos <= '0;
            full_q  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        full_q  <= mode_in.full;
                        step_q  <= sel_step;
                        samp_q  <= sel_samp;
                        bit_pos <= sel_top;
                        cnt     <= '0;
                        phase   <= (sel_samp == '0) ? PH_TRIAL : PH_SAMPLE;
                    end
                end
                PH_SAMPLE: begin
                    if (cnt == samp_q - CNT_W'(1)) begin
                        cnt   <= '0;
                        phase <= PH_TRIAL;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_TRIAL: begin
                    if (cnt == step_q - CNT_W'(1)) begin
                        cnt <= '0;
                        if (bit_pos == '0) begin
                            phase <= PH_IDLE;
                        end else begin
                            bit_pos <= bit_pos - IDX_W'(1);
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign trial_on  = (phase == PH_TRIAL);
    assign decide    = trial_on && (cnt == step_q - CNT_W'(1));
    assign final_bit = decide && (bit_pos == '0);

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
    parameter int FULL_BITS = 10,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic                 trial_on,
    input  logic                 decide,
    input  logic [IDX_W-1:0]     bit_pos,
    input  logic                 cmp_hi,
    output logic [FULL_BITS-1:0] trial_code,
    output logic [FULL_BITS-1:0] settled
);

    logic [FULL_BITS-1:0] acc;
    logic [FULL_BITS-1:0] probe;

    always_comb begin
        probe   = FULL_BITS'(1) << bit_pos;
        settled = cmp_hi ? (acc | probe) : acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (go) begin
            acc <= '0;
        end else if (decide) begin
            acc <= settled;
        end
    end

    assign trial_code = trial_on ? (acc | probe) : '0;

endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
    parameter int FULL_BITS  = 10,
    parameter int SHORT_BITS = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            final_bit,
    input  logic                            full_mode,
    input  logic [FULL_BITS-1:0]            settled,
    output logic                            done,
    output logic [SHORT_BITS-1:0]           res_lo,
    output logic [FULL_BITS-SHORT_BITS-1:0] res_hi
);

    localparam int HI_W = FULL_BITS - SHORT_BITS;

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            res_lo <= '0;
            res_hi <= '0;
        end else begin
            done <= final_bit;
            if (final_bit) begin
                res_lo <= settled[SHORT_BITS-1:0];
                res_hi <= full_mode ? settled[FULL_BITS-1:SHORT_BITS] : HI_W'(0);
            end
        end
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int FULL_BITS    = 10,
    parameter int SHORT_BITS   = 8,
    parameter int CYC_SHORT    = 49,
    parameter int CYC_FULL     = 59,
    parameter int CYC_SHORT_SH = 28,
    parameter int CYC_FULL_SH  = 33,
    parameter int STEP_PLAIN   = 5,
    parameter int STEP_SH      = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ref_en,
    input  logic                            start,
    input  logic                            res_full,
    input  logic                            hold_en,
    input  logic                            cmp_hi,
    output logic                            busy,
    output logic                            done,
    output logic [SHORT_BITS-1:0]           res_lo,
    output logic [FULL_BITS-SHORT_BITS-1:0] res_hi,
    output logic [FULL_BITS-1:0]            trial_code
);

    localparam int CYC_MAX   = max_of4(CYC_SHORT, CYC_FULL, CYC_SHORT_SH, CYC_FULL_SH);
    localparam int CNT_W     = $clog2(CYC_MAX + 1);
    localparam int IDX_W     = $clog2(FULL_BITS);
    localparam int SAMP_S    = sample_len(CYC_SHORT,    SHORT_BITS, STEP_PLAIN);
    localparam int SAMP_F    = sample_len(CYC_FULL,     FULL_BITS,  STEP_PLAIN);
    localparam int SAMP_S_SH = sample_len(CYC_SHORT_SH, SHORT_BITS, STEP_SH);
    localparam int SAMP_F_SH = sample_len(CYC_FULL_SH,  FULL_BITS,  STEP_SH);

    sar_mode_t            mode_in;
    logic                 go;
    logic                 trial_on;
    logic                 decide;
    logic                 final_bit;
    logic                 full_q;
    logic [IDX_W-1:0]     bit_pos;
    logic [FULL_BITS-1:0] settled;

    assign mode_in.full = res_full;
    assign mode_in.hold = hold_en;
    assign go           = start & ref_en & ~busy;

    sar_seq_timer #(
        .FULL_BITS (FULL_BITS),
        .SHORT_BITS(SHORT_BITS),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W),
        .STEP_PLAIN(STEP_PLAIN),
        .STEP_SH   (STEP_SH),
        .SAMP_S    (SAMP_S),
        .SAMP_F    (SAMP_F),
        .SAMP_S_SH (SAMP_S_SH),
        .SAMP_F_SH (SAMP_F_SH)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .mode_in  (mode_in),
        .busy     (busy),
        .trial_on (trial_on),
        .bit_pos  (bit_pos),
        .decide   (decide),
        .final_bit(final_bit),
        .full_q   (full_q)
    );

    sar_bit_reg #(
        .FULL_BITS(FULL_BITS),
        .IDX_W    (IDX_W)
    ) u_bits (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .trial_on  (trial_on),
        .decide    (decide),
        .bit_pos   (bit_pos),
        .cmp_hi    (cmp_hi),
        .trial_code(trial_code),
        .settled   (settled)
    );

    sar_result_fmt #(
        .FULL_BITS (FULL_BITS),
        .SHORT_BITS(SHORT_BITS)
    ) u_fmt (
        .clk      (clk),
        .rst      (rst),
        .final_bit(final_bit),
        .full_mode(full_q),
        .settled  (settled),
        .done     (done),
        .res_lo   (res_lo),
        .res_hi   (res_hi)
    );

endmodule

// File: rtl/sar_conv_ctrl_checker.sv
module sar_conv_ctrl_checker #(
    parameter int FULL_BITS    = 10,
    parameter int SHORT_BITS   = 8,
    parameter int CYC_SHORT    = 49,
    parameter int CYC_FULL     = 59,
    parameter int CYC_SHORT_SH = 28,
    parameter int CYC_FULL_SH  = 33
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            ref_en,
    input logic                            start,
    input logic                            res_full,
    input logic                            hold_en,
    input logic                            busy,
    input logic                            done,
    input logic [SHORT_BITS-1:0]           res_lo,
    input logic [FULL_BITS-SHORT_BITS-1:0] res_hi,
    input logic [FULL_BITS-1:0]            trial_code
);

    logic [15:0] elapsed;
    logic        cap_full;
    logic        cap_hold;
    logic [15:0] want_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed  <= '0;
            cap_full <= 1'b0;
            cap_hold <= 1'b0;
        end else if (start && ref_en && !busy) begin
            elapsed  <= '0;
            cap_full <= res_full;
            cap_hold <= hold_en;
        end else if (busy) begin
            elapsed <= elapsed + 16'd1;
        end
    end

    always_comb begin
        unique case ({cap_full, cap_hold})
            2'b00:   want_len = 16'(CYC_SHORT);
            2'b10:   want_len = 16'(CYC_FULL);
            2'b01:   want_len = 16'(CYC_SHORT_SH);
            default: want_len = 16'(CYC_FULL_SH);
        endcase
    end

    assert_ref_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !ref_en && !busy) |=> !busy);

    assert_length_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (elapsed == want_len));

    assert_idle_code_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (trial_code == '0));

    assert_single_done_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_short_hi_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !cap_full) |-> (res_hi == '0));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable({res_hi, res_lo})));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_checker #(
    .FULL_BITS   (FULL_BITS),
    .SHORT_BITS  (SHORT_BITS),
    .CYC_SHORT   (CYC_SHORT),
    .CYC_FULL    (CYC_FULL),
    .CYC_SHORT_SH(CYC_SHORT_SH),
    .CYC_FULL_SH (CYC_FULL_SH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_en    (ref_en),
    .start     (start),
    .res_full  (res_full),
    .hold_en   (hold_en),
    .busy      (busy),
    .done      (done),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .trial_code(trial_code)
);

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
module sar_conv_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b0;
    logic       start = 1'b0;
    logic       res_full = 1'b0;
    logic       hold_en = 1'b0;
    logic [9:0] vin = 10'd0;
    logic       cmp_hi;
    logic       busy;
    logic       done;
    logic [7:0] res_lo;
    logic [1:0] res_hi;
    logic [9:0] trial_code;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // reference model state
    int m_busy = 0, m_c = 0, m_T = 0, m_N = 0, m_K = 0, m_S = 0;
    int m_acc = 0, m_lo = 0, m_hi = 0, m_done = 0;

    always #2 clk = ~clk;

    // comparator and ladder model: analog level against trial code
    assign cmp_hi = (vin >= trial_code);

    sar_conv_ctrl u_sar_conv_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ref_en    (ref_en),
        .start     (start),
        .res_full  (res_full),
        .hold_en   (hold_en),
        .cmp_hi    (cmp_hi),
        .busy      (busy),
        .done      (done),
        .res_lo    (res_lo),
        .res_hi    (res_hi),
        .trial_code(trial_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic int exp_trial();
        int b;
        if (m_busy != 0 && m_c > m_S) begin
            b = m_N - 1 - (m_c - m_S - 1) / m_K;
            return m_acc | (1 << b);
        end
        return 0;
    endfunction

    // behavioural reference, one step per rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_c = 0; m_acc = 0; m_lo = 0; m_hi = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_busy != 0) begin
                if (m_c > m_S && ((m_c - m_S) % m_K) == 0) begin
                    int b;
                    b = m_N - 1 - ((m_c - m_S) / m_K - 1);
                    if (int'(vin) >= (m_acc | (1 << b))) m_acc = m_acc | (1 << b);
                end
                if (m_c == m_T) begin
                    m_busy = 0;
                    m_done = 1;
                    m_lo = m_acc & 255;
                    m_hi = m_acc >> 8;
                end else begin
                    m_c++;
                end
            end else if (start && ref_en) begin
                m_busy = 1;
                m_c = 1;
                m_N = res_full ? 10 : 8;
                m_K = hold_en ? 3 : 5;
                m_T = res_full ? (hold_en ? 33 : 59) : (hold_en ? 28 : 49);
                m_S = m_T - m_N * m_K;
                m_acc = 0;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(int'(busy) == m_busy, "R3 busy", int'(busy), m_busy);
            check(int'(done) == m_done, "R7 done", int'(done), m_done);
            check(int'(trial_code) == exp_trial(), "R5 trial_code", int'(trial_code), exp_trial());
            check(int'(res_lo) == m_lo, "R9 res_lo", int'(res_lo), m_lo);
            check(int'(res_hi) == m_hi, "R8 res_hi", int'(res_hi), m_hi);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic run_conv(input bit full, input bit hold, input int v,
                            input int exp_len, input bit disturb);
        int n;
        int r;
        int first_code_at;
        @(negedge clk);
        res_full = full;
        hold_en  = hold;
        vin      = 10'(v);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        first_code_at = 0;
        while (!done && n < 200) begin
            if (first_code_at == 0 && trial_code != 10'd0) first_code_at = n;
            if (disturb && n == 3) begin
                start = 1'b1; res_full = ~full; hold_en = ~hold;
            end
            if (disturb && n == 6) start = 1'b0;
            @(negedge clk);
            n++;
        end
        // R3: done seen on the falling edge after the final edge
        check(n - 1 == exp_len, "R3 conversion length", n - 1, exp_len);
        // R4: first nonzero code appears after the sampling cycles
        check(first_code_at == exp_len - (full ? 10 : 8) * (hold ? 3 : 5) + 1,
              "R4 sampling phase", first_code_at,
              exp_len - (full ? 10 : 8) * (hold ? 3 : 5) + 1);
        r = full ? v : ((v > 255) ? 255 : v);
        // R6: bit decisions settle to the analog level
        check(int'(res_lo) == (r & 255), "R6 result low byte", int'(res_lo), r & 255);
        check(int'(res_hi) == (r >> 8), "R8 result high field", int'(res_hi), r >> 8);
        @(negedge clk);
        check(done == 1'b0, "R7 done single pulse", int'(done), 0);
        if (disturb) begin
            res_full = full;
            hold_en = hold;
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'({busy, done}), 0);
        check(res_lo == 8'd0 && res_hi == 2'd0, "R1 reset result", int'({res_hi, res_lo}), 0);
        check(trial_code == 10'd0, "R1 reset trial code", int'(trial_code), 0);
        rst = 1'b0;

        // R2: start with ladder disconnected is ignored
        ref_en = 1'b0;
        vin = 10'd500;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R2 no start without ref_en", int'(busy), 0);
        check(trial_code == 10'd0, "R2 code idle without ref_en", int'(trial_code), 0);

        ref_en = 1'b1;
        run_conv(1'b0, 1'b0, 200, 49, 1'b0);
        run_conv(1'b1, 1'b0, 700, 59, 1'b0);
        run_conv(1'b0, 1'b1, 0, 28, 1'b0);
        run_conv(1'b1, 1'b1, 1023, 33, 1'b0);
        run_conv(1'b0, 1'b0, 300, 49, 1'b0);
        // R10: start and mode changes while busy are ignored
        run_conv(1'b1, 1'b1, 513, 33, 1'b1);
        run_conv(1'b0, 1'b1, 170, 28, 1'b1);
        run_conv(1'b1, 1'b0, 341, 59, 1'b0);

        // R9: result holds while idle with changing analog level
        vin = 10'd3;
        repeat (12) @(negedge clk);
        check(int'({res_hi, res_lo}) == 341, "R9 result held idle", int'({res_hi, res_lo}), 341);

        // R2: result untouched by a rejected start
        ref_en = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (70) @(negedge clk);
        check(busy == 1'b0, "R2 rejected start idle", int'(busy), 0);
        check(int'({res_hi, res_lo}) == 341, "R2 result unchanged", int'({res_hi, res_lo}), 341);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule